// File: doc/BRIEF.md
# HDLC Receive Deframer with Byte FIFO and Fill-Level Interrupt

This block takes the data-link bits of a framed line, one bit per strobe, and recovers HDLC frames from them. It finds the flag pattern that opens and closes each frame, drops the zeros that the sender stuffed after runs of five ones, and packs the remaining bits into bytes, least significant bit first. Each complete byte is pushed into a 64-entry receive FIFO. A processor empties the FIFO through one data port, where the oldest byte is always visible.

A status byte reports several things: the end of a message, the result of a CRC-16 check over the frame, overflow, abort, and the FIFO fill levels. An interrupt line signals the processor. A mode input picks what raises it. In one mode it fires on reaching half full or on end of message. In the other mode it fires on full, overflow or end of message. Reading the status byte clears the interrupt and the sticky flags. When the enable input is low, the receiver and its interrupt stay in reset.

Top module: `hdlc_rx_top`

## Requirements
- R1: A flag (0x7E) opens and closes a frame and is never written to the FIFO. The bytes between two flags are stored LSB-first, in arrival order, with the two FCS bytes included. `fifo_data` shows the oldest byte, and `fifo_pop` removes it.
- R2: Inside a frame, a 0 that follows five consecutive data 1s is removed before the byte is assembled.
- R3: The FIFO holds 64 bytes. A byte that arrives while the FIFO is full is dropped, and status bit 2 (overflow) is set and stays set.
- R4: A closing flag that ends a frame holding at least one byte sets status bit 0 (end of message), and this bit stays set.
- R5: Status bit 1 is 1 when the CRC-16 (x^16+x^12+x^5+1, seed 0xFFFF, reflected) run over data plus FCS gives the residue 0xF0B8 and the frame ended on a byte boundary. Otherwise it is 0. The bit is updated at each end of message.
- R6: Seven consecutive 1s abort the current frame. If the frame had already received bits, status bit 3 (abort) is set. No end of message and no interrupt result from an abort.
- R7: With `half_irq_mode`=1, `irq` rises on an end of message or when the FIFO occupancy reaches 32. Full and overflow do not raise it in this mode.
- R8: With `half_irq_mode`=0, `irq` rises on FIFO full, on overflow or on end of message, but not on reaching half full.
- R9: A pulse on `status_rd` clears `irq` and status bits 0, 2 and 3.
- R10: While `rx_enable`=0, the receiver, the FIFO and all flags are held cleared, `irq` is 0, and incoming bits are ignored.
- R11: After reset, `status` is 0x40 (bit 6 = empty, bit 5 = full, bit 4 = half or more) and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_enable | input | 1 | Receiver enable; low holds the block cleared |
| half_irq_mode | input | 1 | 1: interrupt on half full or end of message; 0: on full, overflow or end of message |
| bit_valid | input | 1 | Strobe qualifying `bit_in` |
| bit_in | input | 1 | Serial data-link bit |
| fifo_pop | input | 1 | Remove the byte shown on `fifo_data` |
| fifo_data | output | 8 | Oldest byte in the FIFO |
| status_rd | input | 1 | Status read strobe; clears the interrupt and the sticky flags |
| status | output | 8 | Status byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench sends payloads made up of flag-valued bytes and runs of five ones. A design that skipped destuffing, or that let flag bits into the data, would return the wrong bytes. A corrupted FCS must clear the CRC bit. An abort placed straight after data must leave the bytes that were already received, and must not produce an end of message. Occupancy is stepped through 31 and then 32 bytes, and then past 64, in both interrupt modes. A design with an off-by-one threshold would fail here, as would one that confused the two modes' conditions or kept the byte written while full. Disabling the receiver during a frame must leave the status empty and the interrupt low.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    localparam int BYTE_W = 8;
    localparam int STUFF_RUN = 5;
    localparam logic [7:0] FLAG_PATTERN = 8'h7E;
    localparam logic [15:0] CRC_SEED = 16'hFFFF;
    localparam logic [15:0] CRC_GOOD = 16'hF0B8;
    localparam logic [15:0] CRC_POLY_R = 16'h8408;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic spare;
        logic empty;
        logic full;
        logic half;
        logic aborted;
        logic overflow;
        logic crc_pass;
        logic eom;
    } rx_status_t;

    typedef struct packed {
        logic  push;
        byte_t data;
        logic  eom;
        logic  abort;
        logic  crc_pass;
    } deframe_evt_t;

    function automatic logic [15:0] crc_bit(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[0] ^ b;
        return (c >> 1) ^ (fb ? CRC_POLY_R : 16'h0000);
    endfunction

endpackage

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
    import hdlc_rx_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         enable,
    input  logic         bit_valid,
    input  logic         bit_in,
    output deframe_evt_t evt
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [3:0] SKIP_LOAD = 4'(BYTE_W);
    localparam logic [2:0] RUN_LIM = 3'(STUFF_RUN);

    logic             clr;
    byte_t            win, win_n, sh, sh_n;
    logic [3:0]       skip, skip_n;
    logic             in_frame, in_frame_n, have, have_n, exit_b;
    logic [2:0]       ones, ones_n;
    logic [CNT_W-1:0] bitcnt, bitcnt_n;
    logic [15:0]      crc, crc_n;

    assign clr = rst | ~enable;

    always_comb begin
        win_n = win; skip_n = skip; in_frame_n = in_frame; have_n = have;
        ones_n = ones; bitcnt_n = bitcnt; sh_n = sh; crc_n = crc;
        exit_b = win[BYTE_W-1];
        evt = '0;
        if (bit_valid) begin
            win_n = {win[BYTE_W-2:0], bit_in};
            if (skip != 4'd0) begin
                skip_n = skip - 4'd1;
            end else if (in_frame) begin
                if (ones == RUN_LIM && !exit_b) begin
                    ones_n = '0;
                end else begin
                    ones_n = exit_b ? ((ones == 3'd7) ? ones : ones + 3'd1) : 3'd0;
                    sh_n = {exit_b, sh[BYTE_W-1:1]};
                    crc_n = crc_bit(crc, exit_b);
                    bitcnt_n = bitcnt + 1'b1;
                    if (bitcnt == LAST_BIT) begin
                        evt.push = 1'b1;
                        evt.data = sh_n;
                        have_n = 1'b1;
                    end
                end
            end
            if (win_n == FLAG_PATTERN) begin
                if (in_frame && have_n) begin
                    evt.eom = 1'b1;
                    evt.crc_pass = (crc_n == CRC_GOOD) && (bitcnt_n == '0);
                end
                in_frame_n = 1'b1;
                skip_n = SKIP_LOAD;
                ones_n = '0;
                bitcnt_n = '0;
                crc_n = CRC_SEED;
                have_n = 1'b0;
            end else if (in_frame && (&win_n[BYTE_W-2:0])) begin
                evt.abort = have_n || (bitcnt_n != '0);
                in_frame_n = 1'b0;
                have_n = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            win <= '0; skip <= '0; in_frame <= 1'b0; have <= 1'b0;
            ones <= '0; bitcnt <= '0; sh <= '0; crc <= CRC_SEED;
        end else begin
            win <= win_n; skip <= skip_n; in_frame <= in_frame_n; have <= have_n;
            ones <= ones_n; bitcnt <= bitcnt_n; sh <= sh_n; crc <= crc_n;
        end
    end

    assert_abort_no_eom_R6: assert property (@(posedge clk) disable iff (rst)
        evt.abort |-> !evt.eom);
    assert_push_in_frame_R1: assert property (@(posedge clk) disable iff (rst)
        evt.push |-> in_frame);
    assert_flag_opens_R1: assert property (@(posedge clk) disable iff (rst)
        (enable && bit_valid && win_n == FLAG_PATTERN) |=> in_frame);

endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo
    import hdlc_rx_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  enable,
    input  logic  push,
    input  byte_t wdata,
    input  logic  pop,
    output byte_t rdata,
    output logic  lvl_half,
    output logic  lvl_full,
    output logic  lvl_empty,
    output logic  ovf_evt
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] CAP = (AW + 1)'(DEPTH);
    localparam logic [AW:0] HALF = (AW + 1)'(DEPTH / 2);

    byte_t         mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          clr, do_push, do_pop;

    assign clr       = rst | ~enable;
    assign lvl_full  = (cnt == CAP);
    assign lvl_empty = (cnt == '0);
    assign lvl_half  = (cnt >= HALF);
    assign do_push   = push & ~lvl_full;
    assign do_pop    = pop & ~lvl_empty;
    assign ovf_evt   = push & lvl_full & enable;
    assign rdata     = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            wp <= '0; rp <= '0; cnt <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop) rp <= rp + 1'b1;
            cnt <= cnt + (AW + 1)'(do_push) - (AW + 1)'(do_pop);
        end
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        cnt <= CAP);
    assert_drop_full_R3: assert property (@(posedge clk) disable iff (rst)
        (enable && lvl_full && push && !pop) |=> ($stable(wp) && lvl_full));

endmodule

// File: rtl/hdlc_rx_irq.sv
module hdlc_rx_irq
    import hdlc_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       half_mode,
    input  logic       eom_evt,
    input  logic       abort_evt,
    input  logic       ovf_evt,
    input  logic       crc_pass,
    input  logic       lvl_half,
    input  logic       lvl_full,
    input  logic       lvl_empty,
    input  logic       stat_rd,
    output rx_status_t status,
    output logic       irq
);
    logic clr, half_prev, full_prev, set_irq;
    logic eom_q, ovf_q, abort_q, crc_q, irq_q;

    assign clr = rst | ~enable;
    assign set_irq = eom_evt | (half_mode ? (lvl_half & ~half_prev)
                                          : ((lvl_full & ~full_prev) | ovf_evt));

    always_ff @(posedge clk) begin
        if (clr) begin
            half_prev <= 1'b0; full_prev <= 1'b0;
            eom_q <= 1'b0; ovf_q <= 1'b0; abort_q <= 1'b0; crc_q <= 1'b0; irq_q <= 1'b0;
        end else begin
            half_prev <= lvl_half;
            full_prev <= lvl_full;
            eom_q   <= eom_evt   | (eom_q   & ~stat_rd);
            ovf_q   <= ovf_evt   | (ovf_q   & ~stat_rd);
            abort_q <= abort_evt | (abort_q & ~stat_rd);
            if (eom_evt) crc_q <= crc_pass;
            irq_q <= set_irq | (irq_q & ~stat_rd);
        end
    end

    always_comb begin
        status = '0;
        status.empty    = lvl_empty;
        status.full     = lvl_full;
        status.half     = lvl_half;
        status.aborted  = abort_q;
        status.overflow = ovf_q;
        status.crc_pass = crc_q;
        status.eom      = eom_q;
    end
    assign irq = irq_q;

    assert_irq_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (enable && stat_rd && !set_irq) |=> !irq);
    assert_irq_off_R10: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!irq && !status.eom));
    assert_eom_irq_R7: assert property (@(posedge clk) disable iff (rst)
        (enable && eom_evt) |=> (irq && status.eom));

endmodule

// File: rtl/hdlc_rx_top.sv
module hdlc_rx_top
    import hdlc_rx_pkg::*;
#(
    parameter int FIFO_DEPTH = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_enable,
    input  logic       half_irq_mode,
    input  logic       bit_valid,
    input  logic       bit_in,
    input  logic       fifo_pop,
    output logic [7:0] fifo_data,
    input  logic       status_rd,
    output logic [7:0] status,
    output logic       irq
);
    deframe_evt_t evt;
    rx_status_t   st;
    logic         lvl_half, lvl_full, lvl_empty, ovf_evt;

    hdlc_rx_deframer u_deframer (
        .clk(clk), .rst(rst), .enable(rx_enable),
        .bit_valid(bit_valid), .bit_in(bit_in), .evt(evt)
    );

    hdlc_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .enable(rx_enable),
        .push(evt.push), .wdata(evt.data), .pop(fifo_pop), .rdata(fifo_data),
        .lvl_half(lvl_half), .lvl_full(lvl_full), .lvl_empty(lvl_empty),
        .ovf_evt(ovf_evt)
    );

    hdlc_rx_irq u_irq (
        .clk(clk), .rst(rst), .enable(rx_enable), .half_mode(half_irq_mode),
        .eom_evt(evt.eom), .abort_evt(evt.abort), .ovf_evt(ovf_evt),
        .crc_pass(evt.crc_pass), .lvl_half(lvl_half), .lvl_full(lvl_full),
        .lvl_empty(lvl_empty), .stat_rd(status_rd), .status(st), .irq(irq)
    );

    assign status = st;

endmodule

// File: tb/hdlc_rx_top_test.sv
module hdlc_rx_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // {len, bad_fcs, d0, d1, d2, d3}
    localparam logic [47:0] VEC [NVEC] = '{
        {8'd1, 8'd0, 8'h7E, 8'h00, 8'h00, 8'h00},
        {8'd2, 8'd0, 8'hFF, 8'h1F, 8'h00, 8'h00},
        {8'd3, 8'd0, 8'h00, 8'hA5, 8'h3C, 8'h00},
        {8'd4, 8'd1, 8'hF8, 8'hFF, 8'hFF, 8'h01},
        {8'd2, 8'd1, 8'h12, 8'h34, 8'h00, 8'h00},
        {8'd4, 8'd0, 8'h3E, 8'h7C, 8'hF9, 8'hBE}
    };

    logic clk = 0, rst = 1, rx_enable = 0, half_irq_mode = 1;
    logic bit_valid = 0, bit_in = 0, fifo_pop = 0, status_rd = 0;
    logic [7:0] fifo_data, status;
    logic irq;
    int checks = 0, fails = 0, ones_run = 0, next_val = 0;
    logic [7:0] pay [0:79];

    always #(CLK_PERIOD / 2) clk = ~clk;

    hdlc_rx_top uut (
        .clk(clk), .rst(rst), .rx_enable(rx_enable), .half_irq_mode(half_irq_mode),
        .bit_valid(bit_valid), .bit_in(bit_in), .fifo_pop(fifo_pop),
        .fifo_data(fifo_data), .status_rd(status_rd), .status(status), .irq(irq)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b);
        bit_valid = 1; bit_in = b;
        @(negedge clk);
        bit_valid = 0;
    endtask

    task automatic send_flag();
        for (int i = 0; i < 8; i++) drive_bit(8'h7E >> i);
        ones_run = 0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) begin
            drive_bit(v[i]);
            ones_run = v[i] ? ones_run + 1 : 0;
            if (ones_run == 5) begin drive_bit(1'b0); ones_run = 0; end
        end
    endtask

    task automatic send_abort_tail();
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(1'b1);
    endtask

    function automatic logic [15:0] fcs_of(input int n);
        logic [15:0] c = 16'hFFFF;
        for (int k = 0; k < n; k++)
            for (int i = 0; i < 8; i++)
                c = ((c[0] ^ pay[k][i]) != 0) ? ((c >> 1) ^ 16'h8408) : (c >> 1);
        return ~c;
    endfunction

    task automatic send_good_frame(input int n, input bit bad);
        logic [15:0] f = fcs_of(n) ^ (bad ? 16'h0001 : 16'h0000);
        pay[n] = f[7:0]; pay[n+1] = f[15:8];
        send_flag();
        for (int k = 0; k < n + 2; k++) send_byte(pay[k]);
        send_flag();
        repeat (2) @(negedge clk);
    endtask

    task automatic send_aborted_run(input int n);
        send_flag();
        for (int k = 0; k < n; k++) begin send_byte(8'(next_val)); next_val++; end
        send_abort_tail();
        repeat (2) @(negedge clk);
    endtask

    task automatic pop_expect(input string req, input int exp);
        check(req, "fifo_data", int'(fifo_data), exp);
        fifo_pop = 1; @(negedge clk); fifo_pop = 0;
    endtask

    task automatic read_status();
        status_rd = 1; @(negedge clk); status_rd = 0;
    endtask

    task automatic flush();
        rx_enable = 0; repeat (2) @(negedge clk); rx_enable = 1; @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0; @(negedge clk);
        // R11: reset state
        check("R11", "status after reset", int'(status), 8'h40);
        check("R11", "irq after reset", int'(irq), 0);

        // R10: bits ignored while disabled
        pay[0] = 8'h55;
        send_good_frame(1, 0);
        check("R10", "status while disabled", int'(status), 8'h40);
        check("R10", "irq while disabled", int'(irq), 0);
        rx_enable = 1; @(negedge clk);

        // R1 R2 R4 R5 R7 R9: vector table walk, half mode
        half_irq_mode = 1;
        for (int v = 0; v < NVEC; v++) begin
            int n = int'(VEC[v][47:40]);
            bit bad = VEC[v][32];
            for (int k = 0; k < 4; k++) pay[k] = VEC[v][31 - 8*k -: 8];
            send_good_frame(n, bad);
            check("R4", "eom bit", int'(status[0]), 1);
            check("R5", "crc bit", int'(status[1]), bad ? 0 : 1);
            check("R7", "irq on eom", int'(irq), 1);
            for (int k = 0; k < n + 2; k++) pop_expect("R2", int'(pay[k]));
            check("R1", "empty after frame", int'(status[6]), 1);
            read_status();
            check("R9", "irq after status read", int'(irq), 0);
            check("R9", "eom after status read", int'(status[0]), 0);
        end

        // R6: abort after data keeps bytes, no eom, no irq
        send_flag(); send_byte(8'h55); send_byte(8'h66); send_abort_tail();
        repeat (2) @(negedge clk);
        check("R6", "abort bit", int'(status[3]), 1);
        check("R6", "eom bit on abort", int'(status[0]), 0);
        check("R6", "irq on abort", int'(irq), 0);
        pop_expect("R6", 8'h55);
        pop_expect("R6", 8'h66);
        read_status();
        check("R9", "abort bit cleared", int'(status[3]), 0);

        // R7: half threshold at 32, overflow silent in half mode
        flush(); next_val = 0;
        send_aborted_run(31);
        check("R7", "irq at 31 bytes", int'(irq), 0);
        check("R7", "half bit at 31", int'(status[4]), 0);
        send_aborted_run(1);
        check("R7", "irq at 32 bytes", int'(irq), 1);
        read_status();
        check("R9", "irq cleared with half still set", int'(irq), 0);
        send_aborted_run(33);
        check("R3", "overflow bit", int'(status[2]), 1);
        check("R3", "full bit", int'(status[5]), 1);
        check("R7", "irq on overflow in half mode", int'(irq), 0);
        for (int k = 0; k < 64; k++) pop_expect("R3", k);
        check("R3", "empty after 64 pops", int'(status[6]), 1);

        // R8: full / overflow mode
        flush(); half_irq_mode = 0;
        send_aborted_run(40);
        check("R8", "no irq at half in full mode", int'(irq), 0);
        send_aborted_run(24);
        check("R8", "irq on full", int'(irq), 1);
        check("R8", "no overflow yet", int'(status[2]), 0);
        read_status();
        check("R9", "irq cleared", int'(irq), 0);
        send_aborted_run(1);
        check("R8", "irq on overflow", int'(irq), 1);
        check("R3", "overflow sticky", int'(status[2]), 1);

        // R10: disabling clears irq and FIFO
        rx_enable = 0; @(negedge clk); @(negedge clk);
        check("R10", "irq after disable", int'(irq), 0);
        check("R10", "status after disable", int'(status), 8'h40);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule